// File: doc/BRIEF.md
# Five-Operation Operand Shifter

This block scales a register operand before it is used, either as the offset of a memory address or as the second operand of a data-processing operation. It takes a 32-bit value, a 3-bit shift kind, a 5-bit shift count taken from an immediate field, and the current carry flag. It returns the shifted value together with a shifter carry-out.

The supported kinds are:

- logical left shift;
- logical right shift;
- arithmetic right shift;
- rotate right;
- an extended rotate right, in which the carry flag acts as a 33rd bit of the rotation.

The block holds no state. Both outputs follow the inputs within the same cycle, so the block can sit directly between the register read and the address adder or the ALU.

Top module: `opshift`

## Requirements
- R1: Kind 3'b000 with a nonzero count n shifts the value left by n positions and fills with zeros. The carry-out is input bit 32-n, which is the last bit shifted out.
- R2: Kind 3'b001 with a nonzero count n shifts the value right by n positions and fills with zeros. The carry-out is input bit n-1.
- R3: Kind 3'b010 with a nonzero count n shifts the value right by n positions and fills the vacated upper positions with copies of input bit 31. The carry-out is input bit n-1.
- R4: Kind 3'b011 with a nonzero count n rotates the value right by n positions, so that input bit i reaches result bit (i-n) mod 32. The carry-out is input bit n-1, which equals result bit 31.
- R5: Kind 3'b100 moves the value right by exactly one position. The incoming carry enters result bit 31, and input bit 0 becomes the carry-out. The count input has no effect on either output.
- R6: For kinds 3'b000 through 3'b011, a count of zero returns the value unchanged and returns the incoming carry as the carry-out.
- R7: Kind codes 3'b101, 3'b110 and 3'b111 return the value unchanged and return the incoming carry as the carry-out, whatever the count.
- R8: Both outputs are purely combinational. A change on any input is visible on the outputs without any clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opnd_i | input | 32 | Operand to be shifted |
| kind_i | input | 3 | Shift kind code (see R1 to R7) |
| amt_i | input | 5 | Immediate shift count |
| cin_i | input | 1 | Current carry flag |
| result_o | output | 32 | Shifted operand |
| cout_o | output | 1 | Shifter carry-out |

## Verification
The checker evaluates immediate assertions whenever the ports change. It therefore assumes that the outputs have settled on the same inputs that it reads, and that all inputs hold known 0/1 values.

The bench keeps to this assumption. It changes all inputs together on a falling clock edge and compares the outputs one time unit later. It never leaves an input undriven, and it sweeps every kind code, including the three unused codes, at counts of 0, 1, 31 and pseudo-random values.

// File: rtl/opshift_pkg.sv
package opshift_pkg;

    typedef enum logic [2:0] {
        SK_LSL = 3'b000,
        SK_LSR = 3'b001,
        SK_ASR = 3'b010,
        SK_ROR = 3'b011,
        SK_RXC = 3'b100
    } shift_kind_e;

endpackage

// File: rtl/opshift_left.sv
module opshift_left #(
    parameter int WIDTH = 32,
    localparam int AMT_W = $clog2(WIDTH)
) (
    input  logic [WIDTH-1:0] val_i,
    input  logic [AMT_W-1:0] amt_i,
    output logic [WIDTH-1:0] val_o
);

    logic [WIDTH-1:0] stage_w [AMT_W+1];

    assign stage_w[0] = val_i;

    for (genvar k = 0; k < AMT_W; k++) begin : g_stage
        localparam int STEP = 1 << k;
        assign stage_w[k+1] = amt_i[k]
            ? {stage_w[k][WIDTH-STEP-1:0], {STEP{1'b0}}}
            : stage_w[k];
    end

    assign val_o = stage_w[AMT_W];

endmodule

// File: rtl/opshift_right.sv
module opshift_right #(
    parameter int WIDTH = 32,
    localparam int AMT_W = $clog2(WIDTH)
) (
    input  logic [WIDTH-1:0] val_i,
    input  logic [AMT_W-1:0] amt_i,
    input  logic             sign_fill_i,
    input  logic             wrap_i,
    output logic [WIDTH-1:0] val_o
);

    logic [WIDTH-1:0] stage_w [AMT_W+1];
    logic             fill_bit_w;

    assign fill_bit_w = sign_fill_i & val_i[WIDTH-1];
    assign stage_w[0] = val_i;

    for (genvar k = 0; k < AMT_W; k++) begin : g_stage
        localparam int STEP = 1 << k;
        logic [STEP-1:0] fill_w;
        assign fill_w = wrap_i ? stage_w[k][STEP-1:0] : {STEP{fill_bit_w}};
        assign stage_w[k+1] = amt_i[k]
            ? {fill_w, stage_w[k][WIDTH-1:STEP]}
            : stage_w[k];
    end

    assign val_o = stage_w[AMT_W];

endmodule

// File: rtl/opshift_carry.sv
module opshift_carry #(
    parameter int WIDTH = 32,
    localparam int AMT_W = $clog2(WIDTH)
) (
    input  logic [WIDTH-1:0] val_i,
    input  logic [AMT_W-1:0] amt_i,
    output logic             left_out_o,
    output logic             right_out_o
);

    logic [AMT_W-1:0] left_idx_w;
    logic [AMT_W-1:0] right_idx_w;

    // The count is nonzero whenever these bits are used. WIDTH is a
    // power of two, so WIDTH - n fits in AMT_W bits after wrapping.
    assign left_idx_w  = AMT_W'(WIDTH) - amt_i;
    assign right_idx_w = amt_i - AMT_W'(1);

    assign left_out_o  = val_i[left_idx_w];
    assign right_out_o = val_i[right_idx_w];

endmodule

// File: rtl/opshift.sv
module opshift
    import opshift_pkg::*;
#(
    parameter int WIDTH = 32,
    localparam int AMT_W = $clog2(WIDTH),
    localparam int KIND_W = 3
) (
    input  logic [WIDTH-1:0]  opnd_i,
    input  logic [KIND_W-1:0] kind_i,
    input  logic [AMT_W-1:0]  amt_i,
    input  logic              cin_i,
    output logic [WIDTH-1:0]  result_o,
    output logic              cout_o
);

    typedef struct packed {
        logic [WIDTH-1:0] val;
        logic             carry;
    } shift_res_t;

    shift_res_t res_d;

    logic [WIDTH-1:0] left_val_w;
    logic [WIDTH-1:0] right_val_w;
    logic             left_c_w;
    logic             right_c_w;
    logic             is_asr_w;
    logic             is_ror_w;
    logic             amt_zero_w;

    assign is_asr_w   = (kind_i == SK_ASR);
    assign is_ror_w   = (kind_i == SK_ROR);
    assign amt_zero_w = (amt_i == '0);

    opshift_left #(.WIDTH(WIDTH)) u_left (
        .val_i (opnd_i),
        .amt_i (amt_i),
        .val_o (left_val_w)
    );

    opshift_right #(.WIDTH(WIDTH)) u_right (
        .val_i       (opnd_i),
        .amt_i       (amt_i),
        .sign_fill_i (is_asr_w),
        .wrap_i      (is_ror_w),
        .val_o       (right_val_w)
    );

    opshift_carry #(.WIDTH(WIDTH)) u_carry (
        .val_i       (opnd_i),
        .amt_i       (amt_i),
        .left_out_o  (left_c_w),
        .right_out_o (right_c_w)
    );

    always_comb begin
        res_d.val   = opnd_i;
        res_d.carry = cin_i;
        case (kind_i)
            SK_LSL: begin
                if (!amt_zero_w) begin
                    res_d.val   = left_val_w;
                    res_d.carry = left_c_w;
                end
            end
            SK_LSR, SK_ASR, SK_ROR: begin
                if (!amt_zero_w) begin
                    res_d.val   = right_val_w;
                    res_d.carry = right_c_w;
                end
            end
            SK_RXC: begin
                res_d.val   = {cin_i, opnd_i[WIDTH-1:1]};
                res_d.carry = opnd_i[0];
            end
            default: begin
                res_d.val   = opnd_i;
                res_d.carry = cin_i;
            end
        endcase
    end

    assign result_o = res_d.val;
    assign cout_o   = res_d.carry;

endmodule

// File: rtl/opshift_chk.sv
module opshift_chk #(
    parameter int WIDTH = 32,
    localparam int AMT_W = $clog2(WIDTH)
) (
    input logic [WIDTH-1:0] opnd_i,
    input logic [2:0]       kind_i,
    input logic [AMT_W-1:0] amt_i,
    input logic             cin_i,
    input logic [WIDTH-1:0] result_o,
    input logic             cout_o
);

    always_comb begin
        // R6
        zero_amt_pass_chk: assert (!(kind_i < 3'd4 && amt_i == '0)
                                   || (result_o == opnd_i && cout_o == cin_i));
        // R7
        spare_code_chk: assert (!(kind_i > 3'd4)
                                || (result_o == opnd_i && cout_o == cin_i));
        // R5
        rxc_form_chk: assert (!(kind_i == 3'd4)
                              || (result_o[WIDTH-1] == cin_i && cout_o == opnd_i[0]
                                  && result_o[WIDTH-2:0] == opnd_i[WIDTH-1:1]));
        // R3
        asr_sign_chk: assert (!(kind_i == 3'd2) || result_o[WIDTH-1] == opnd_i[WIDTH-1]);
        // R4
        ror_perm_chk: assert (!(kind_i == 3'd3)
                              || ($countones(result_o) == $countones(opnd_i)
                                  && (amt_i == '0 || cout_o == result_o[WIDTH-1])));
        // R1
        lsl_low_zero_chk: assert (!(kind_i == 3'd0 && amt_i != '0) || result_o[0] == 1'b0);
        // R2
        lsr_top_zero_chk: assert (!(kind_i == 3'd1 && amt_i != '0)
                                  || result_o[WIDTH-1] == 1'b0);
    end

endmodule

bind opshift opshift_chk #(.WIDTH(WIDTH)) u_chk (
    .opnd_i   (opnd_i),
    .kind_i   (kind_i),
    .amt_i    (amt_i),
    .cin_i    (cin_i),
    .result_o (result_o),
    .cout_o   (cout_o)
);

// File: tb/opshift_tb.sv
`timescale 1ns/1ps
module opshift_tb;

    logic        clk = 1'b0;
    logic [31:0] opnd;
    logic [2:0]  kind;
    logic [4:0]  amt;
    logic        cin;
    logic [31:0] result;
    logic        cout;

    int checks   = 0;
    int failures = 0;
    bit done     = 1'b0;

    always #5 clk = ~clk;

    opshift u_dut (
        .opnd_i   (opnd),
        .kind_i   (kind),
        .amt_i    (amt),
        .cin_i    (cin),
        .result_o (result),
        .cout_o   (cout)
    );

    function automatic logic [32:0] model(logic [31:0] x, logic [2:0] k,
                                          logic [4:0] n, logic c);
        logic [31:0] v  = x;
        logic        cy = c;
        case (k)
            3'd0: for (int i = 0; i < int'(n); i++) begin cy = v[31]; v = {v[30:0], 1'b0}; end
            3'd1: for (int i = 0; i < int'(n); i++) begin cy = v[0]; v = {1'b0, v[31:1]}; end
            3'd2: for (int i = 0; i < int'(n); i++) begin cy = v[0]; v = {x[31], v[31:1]}; end
            3'd3: for (int i = 0; i < int'(n); i++) begin cy = v[0]; v = {v[0], v[31:1]}; end
            3'd4: begin cy = x[0]; v = {c, x[31:1]}; end
            default: ;
        endcase
        return {cy, v};
    endfunction

    task automatic apply(input logic [31:0] x, input logic [2:0] k,
                         input logic [4:0] n, input logic c);
        @(negedge clk);
        opnd = x; kind = k; amt = n; cin = c;
        #1;
    endtask

    task automatic expect_out(input string req, input logic [31:0] ev, input logic ec);
        checks++;
        if (result !== ev || cout !== ec) begin
            failures++;
            $display("FAIL %s: kind=%0d amt=%0d in=%h cin=%b got %h/%b expected %h/%b",
                     req, kind, amt, opnd, cin, result, cout, ev, ec);
        end
    endtask

    task automatic run_vec(input string req, input logic [31:0] x, input logic [2:0] k,
                           input logic [4:0] n, input logic c);
        logic [32:0] e;
        apply(x, k, n, c);
        e = model(x, k, n, c);
        expect_out(req, e[31:0], e[32]);
    endtask

    task automatic t_idle;
        apply(32'h0, 3'd0, 5'd0, 1'b0);
        expect_out("R6 idle", 32'h0, 1'b0);
    endtask

    task automatic t_lsl;   // R1
        run_vec("R1", 32'h8000_0001, 3'd0, 5'd1, 1'b0);
        apply(32'h0000_0003, 3'd0, 5'd31, 1'b0);
        expect_out("R1 n=31", 32'h8000_0000, 1'b1);
        run_vec("R1", 32'h1234_5678, 3'd0, 5'd4, 1'b1);
    endtask

    task automatic t_lsr;   // R2
        apply(32'hF000_0001, 3'd1, 5'd1, 1'b0);
        expect_out("R2 n=1", 32'h7800_0000, 1'b1);
        run_vec("R2", 32'h8000_0000, 3'd1, 5'd31, 1'b1);
        run_vec("R2", 32'hDEAD_BEEF, 3'd1, 5'd8, 1'b0);
    endtask

    task automatic t_asr;   // R3
        apply(32'h8000_0000, 3'd2, 5'd31, 1'b0);
        expect_out("R3 n=31", 32'hFFFF_FFFF, 1'b0);
        run_vec("R3", 32'h7FFF_FFF0, 3'd2, 5'd4, 1'b1);
        run_vec("R3", 32'hC000_0008, 3'd2, 5'd4, 1'b0);
    endtask

    task automatic t_ror;   // R4
        apply(32'h0000_0001, 3'd3, 5'd1, 1'b0);
        expect_out("R4 n=1", 32'h8000_0000, 1'b1);
        run_vec("R4", 32'h1234_5678, 3'd3, 5'd16, 1'b0);
        run_vec("R4", 32'hA5A5_0F0F, 3'd3, 5'd31, 1'b1);
    endtask

    task automatic t_rxc;   // R5
        apply(32'h0000_0003, 3'd4, 5'd0, 1'b1);
        expect_out("R5", 32'h8000_0001, 1'b1);
        apply(32'h0000_0003, 3'd4, 5'd17, 1'b1);
        expect_out("R5 amt ignored", 32'h8000_0001, 1'b1);
        apply(32'hFFFF_FFFE, 3'd4, 5'd31, 1'b0);
        expect_out("R5 amt ignored", 32'h7FFF_FFFF, 1'b0);
    endtask

    task automatic t_zero;  // R6
        for (int k = 0; k < 4; k++) begin
            apply(32'h8765_4321, 3'(k), 5'd0, 1'b1);
            expect_out("R6", 32'h8765_4321, 1'b1);
            apply(32'h0000_0001, 3'(k), 5'd0, 1'b0);
            expect_out("R6", 32'h0000_0001, 1'b0);
        end
    endtask

    task automatic t_spare; // R7
        for (int k = 5; k < 8; k++) begin
            apply(32'hCAFE_F00D, 3'(k), 5'd7, 1'b1);
            expect_out("R7", 32'hCAFE_F00D, 1'b1);
            apply(32'h0000_0001, 3'(k), 5'd1, 1'b0);
            expect_out("R7", 32'h0000_0001, 1'b0);
        end
    endtask

    task automatic t_comb;  // R8: outputs move with no clock edge
        apply(32'h0000_00F0, 3'd1, 5'd4, 1'b0);
        expect_out("R8", 32'h0000_000F, 1'b0);
        #1 amt = 5'd5;
        #1 expect_out("R8 mid-cycle", 32'h0000_0007, 1'b1);
    endtask

    task automatic t_sweep;
        logic [31:0] lfsr = 32'h1ACE_B00C;
        for (int i = 0; i < 400; i++) begin
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            run_vec("R1-R7 sweep", lfsr, 3'(i % 8), lfsr[9:5] ^ 5'(i), lfsr[13]);
        end
    endtask

    initial begin
        fork
            begin
                repeat (200000) @(posedge clk);
                if (!done) begin
                    failures++;
                    $display("FAIL watchdog: got timeout expected completion");
                    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
                    $finish;
                end
            end
        join_none
        opnd = '0; kind = '0; amt = '0; cin = 1'b0;
        t_idle();
        t_lsl();
        t_lsr();
        t_asr();
        t_ror();
        t_rxc();
        t_zero();
        t_spare();
        t_comb();
        t_sweep();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule